// File: doc/BRIEF.md
# Universal Shift Register with Hold, Bidirectional Shift and Parallel Load

This block is an n-bit register. A 2-bit mode input selects what the register does on each rising clock edge: keep its contents, shift toward the low-order end, shift toward the high-order end, or take a full parallel word. Each shift direction has its own serial input. The bit that leaves the register during a shift is shown on a serial output. All stage outputs can be read at any time.

An active-low clear acts asynchronously. It zeroes every stage at once without waiting for a clock edge, and it overrides any mode. The block fits wherever a datapath needs a small register that can be loaded, rotated or serialised under per-cycle control. Rotation is done by feeding the serial output back into the matching serial input outside the block.

The mode encoding is the block's set of operating states. The register moves from any state to any other on each edge, as the mode input selects:
- HOLD (00): the contents stay as they are.
- SHIFT_DOWN (01): the contents move one place toward bit 0.
- SHIFT_UP (10): the contents move one place toward bit n-1.
- LOAD (11): the register takes the parallel input word.

Top module: `shift_reg_univ`

## Requirements
- R1: While `clr_n` is 0, `q` is all zeros at every clock edge, whatever the mode.
- R2: With `mode` = 2'b00 (HOLD), `q` after the rising edge equals `q` before it, however many edges arrive.
- R3: With `mode` = 2'b01 (SHIFT_DOWN), after the rising edge `q[i]` takes the old `q[i+1]` for i < n-1, and `q[n-1]` takes `ser_in_hi`.
- R4: With `mode` = 2'b10 (SHIFT_UP), after the rising edge `q[i]` takes the old `q[i-1]` for i > 0, and `q[0]` takes `ser_in_lo`.
- R5: With `mode` = 2'b11 (LOAD), after the rising edge `q` equals the `par_in` value sampled at that edge.
- R6: A falling `clr_n` zeroes `q` before the next clock edge arrives.
- R7: `ser_out` equals `q[0]` in SHIFT_DOWN and `q[n-1]` in SHIFT_UP. In HOLD and LOAD it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; all transfers happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift down, 10 shift up, 11 load |
| ser_in_hi | input | 1 | Serial bit that enters stage n-1 on a down shift |
| ser_in_lo | input | 1 | Serial bit that enters stage 0 on an up shift |
| par_in | input | WIDTH | Parallel load word |
| q | output | WIDTH | Register contents |
| ser_out | output | 1 | Bit that leaves the register in the current shift direction |

## Verification
Any wrong stage value shows up on `q` in the same cycle, because every stage drives the port directly. A wrong neighbour connection or mode decode therefore causes a mismatch one edge after the faulty operation. A fault that only moves bits around, such as swapped directions or the wrong serial input, still changes the value of `q` after the first shift with a non-symmetric pattern. The bench therefore shifts patterns such as 1000 and 0001. A clear that waits for the clock shows up as a non-zero `q` in the half cycle between the falling `clr_n` and the next edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_SHR   = 2'b01,
        OP_SHL   = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    typedef struct packed {
        logic hold;
        logic shr;
        logic shl;
        logic load;
    } sel_t;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] mode,
    output sel_t       sel
);

    always_comb begin
        sel = '0;
        unique case (op_e'(mode))
            OP_HOLD: sel.hold = 1'b1;
            OP_SHR:  sel.shr  = 1'b1;
            OP_SHL:  sel.shl  = 1'b1;
            OP_LOAD: sel.load = 1'b1;
            default: sel.hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/usr_stage.sv
module usr_stage
    import usr_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  sel_t sel,
    input  logic from_hi,
    input  logic from_lo,
    input  logic par_bit,
    output logic bit_q
);

    logic bit_d;

    always_comb begin
        bit_d = bit_q;
        if (sel.shr)       bit_d = from_hi;
        else if (sel.shl)  bit_d = from_lo;
        else if (sel.load) bit_d = par_bit;
        else if (sel.hold) bit_d = bit_q;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

endmodule

// File: rtl/usr_serial_out.sv
module usr_serial_out #(
    parameter int WIDTH = 4
) (
    input  logic             shr,
    input  logic             shl,
    input  logic [WIDTH-1:0] q,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    always_comb begin
        if (shr)      ser_out = q[0];
        else if (shl) ser_out = q[TOP];
        else          ser_out = 1'b0;
    end

endmodule

// File: rtl/shift_reg_univ.sv
module shift_reg_univ
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_hi,
    input  logic             ser_in_lo,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    localparam int EXT_W = WIDTH + 2;

    sel_t             sel;
    logic [EXT_W-1:0] ext;

    assign ext = {ser_in_hi, q, ser_in_lo};

    usr_mode_dec i_dec (
        .mode (mode),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        usr_stage i_stage (
            .clk     (clk),
            .clr_n   (clr_n),
            .sel     (sel),
            .from_hi (ext[i+2]),
            .from_lo (ext[i]),
            .par_bit (par_in[i]),
            .bit_q   (q[i])
        );
    end

    usr_serial_out #(.WIDTH(WIDTH)) i_sout (
        .shr     (sel.shr),
        .shl     (sel.shl),
        .q       (q),
        .ser_out (ser_out)
    );

    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> $stable(q));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q == {$past(ser_in_hi), $past(q[WIDTH-1:1])}));

    assert_shift_up_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in_lo)}));

    assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (q == $past(par_in)));

    assert_ser_out_R7: assert property (@(posedge clk) disable iff (!clr_n)
        ser_out == ((mode == 2'b01) ? q[0] : (mode == 2'b10) ? q[WIDTH-1] : 1'b0));

endmodule

// File: tb/test_shift_reg_univ.sv
module test_shift_reg_univ;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         ser_in_hi = 1'b0;
    logic         ser_in_lo = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;
    logic         ser_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q = '0;
    bit done = 0;

    always #10 clk = ~clk;

    shift_reg_univ #(.WIDTH(W)) i_shift_reg_univ (
        .clk       (clk),
        .clr_n     (clr_n),
        .mode      (mode),
        .ser_in_hi (ser_in_hi),
        .ser_in_lo (ser_in_lo),
        .par_in    (par_in),
        .q         (q),
        .ser_out   (ser_out)
    );

    // behavioural reference: integer arithmetic on the stored value
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) exp_q <= '0;
        else begin
            int v;
            v = int'(exp_q);
            case (mode)
                2'b01: v = (v >> 1) + (ser_in_hi ? (1 << (W-1)) : 0);
                2'b10: v = ((v << 1) % (1 << W)) + (ser_in_lo ? 1 : 0);
                2'b11: v = int'(par_in);
                default: ;
            endcase
            exp_q <= v[W-1:0];
        end
    end

    function automatic string req_of(input logic [1:0] m, input logic c);
        if (!c) return "R1";
        case (m)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_q(input string req);
        checks++;
        if (q !== exp_q) begin
            errors++;
            $display("FAIL %s: q actual %b expected %b", req, q, exp_q);
        end
    endtask

    task automatic check_sout();
        logic e;
        e = (mode == 2'b01) ? exp_q[0] : (mode == 2'b10) ? exp_q[W-1] : 1'b0;
        checks++;
        if (ser_out !== e) begin
            errors++;
            $display("FAIL R7: ser_out actual %b expected %b", ser_out, e);
        end
    endtask

    logic [1:0] last_mode = 2'b00;
    logic       last_clr = 1'b0;
    always @(posedge clk) begin
        last_mode <= mode;
        last_clr  <= clr_n;
    end

    always @(negedge clk) begin
        if (!done) begin
            check_q(req_of(last_mode, last_clr));
            check_sout();
        end
    end

    task automatic step(input logic [1:0] m, input logic hi, input logic lo, input logic [W-1:0] p);
        @(negedge clk);
        #2;
        mode = m; ser_in_hi = hi; ser_in_lo = lo; par_in = p;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with load requested while cleared
        step(2'b11, 1'b0, 1'b0, 4'b1111);
        step(2'b11, 1'b0, 1'b0, 4'b1111);
        @(negedge clk); #2;
        clr_n = 1'b1;
        // R5 load
        step(2'b11, 1'b0, 1'b0, 4'b1010);
        // R2 hold for several edges with noisy inputs
        step(2'b00, 1'b1, 1'b1, 4'b0101);
        step(2'b00, 1'b0, 1'b1, 4'b1111);
        step(2'b00, 1'b1, 1'b0, 4'b0000);
        // R3 shift down, asymmetric pattern
        step(2'b11, 1'b0, 1'b0, 4'b1000);
        step(2'b01, 1'b0, 1'b1, 4'b0000);
        step(2'b01, 1'b1, 1'b0, 4'b0000);
        step(2'b01, 1'b0, 1'b1, 4'b0000);
        step(2'b01, 1'b1, 1'b1, 4'b0000);
        step(2'b01, 1'b0, 1'b0, 4'b0000);
        // R4 shift up
        step(2'b11, 1'b0, 1'b0, 4'b0001);
        step(2'b10, 1'b1, 1'b0, 4'b0000);
        step(2'b10, 1'b0, 1'b1, 4'b0000);
        step(2'b10, 1'b1, 1'b0, 4'b0000);
        step(2'b10, 1'b0, 1'b1, 4'b0000);
        step(2'b10, 1'b0, 1'b0, 4'b0000);
        step(2'b11, 1'b0, 1'b0, 4'b0110);
        step(2'b00, 1'b0, 1'b0, 4'b0000);
        // R6: asynchronous clear mid-cycle, checked before next edge
        @(posedge clk); #5;
        clr_n = 1'b0;
        #1;
        checks++;
        if (q !== '0) begin
            errors++;
            $display("FAIL R6: q actual %b expected %b", q, {W{1'b0}});
        end
        // R1: clear overrides load and shift
        step(2'b11, 1'b1, 1'b1, 4'b1111);
        step(2'b10, 1'b1, 1'b1, 4'b1111);
        @(negedge clk); #2;
        clr_n = 1'b1;
        step(2'b11, 1'b0, 1'b0, 4'b1001);
        step(2'b01, 1'b1, 1'b0, 4'b0000);
        step(2'b10, 1'b0, 1'b1, 4'b0000);
        step(2'b00, 1'b0, 1'b0, 4'b0000);
        @(negedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule